// File: doc/BRIEF.md
# Transmit Slot Mapper

The block sits between a set of per-channel transmit sample FIFOs and a frame serializer. A frame carries a tag slot followed by twelve 20-bit data slots, numbered 1 to 12. Software gives each channel a mask of the data slots it owns and a sample-size code. The mapper checks the whole configuration when it is loaded. On each frame-start pulse it steps through slots 1 to 12, one per clock. For every slot owned by a channel it pops one sample from that channel's FIFO and presents it, left-justified, on the slot data output.

A channel that owns several slots is drained lowest slot first, so the order of words in its FIFO matches the ascending slot order. An illegal configuration raises a sticky error flag and holds the mapper idle until a legal configuration is loaded. When a FIFO is empty at the moment its slot comes up, the mapper sends a zero sample and latches an underrun flag for that channel.

Top module: `slot_tx_mapper`

## Requirements
- R1: After reset, slot_valid, slot_num, slot_data, cfg_err, underrun, busy and fifo_rd_en are all zero.
- R2: A configuration in which any data slot is owned by two or more channels sets cfg_err on the clock edge that loads it. The mask of channel c is cfg_mask[c*12 +: 12], and bit k-1 stands for slot k.
- R3: A configuration in which any channel owns more than 8 slots sets cfg_err. Exactly 8 slots is legal.
- R4: A channel with its cfg_compact bit set may use only size code 0 (12-bit) or 1 (16-bit). Code 2 (18-bit) or code 3 (20-bit) with compact set raises cfg_err. The size code of channel c is cfg_size[c*2 +: 2].
- R5: Suppose slot 1 is owned by one channel and slot 2 by another. Then the channel owning slot 2 must own no other slot, or cfg_err is raised. Every other placement of slots 1 and 2 is legal.
- R6: While cfg_err is set, frame_start is ignored: no FIFO is popped, slot_valid stays low and busy stays low. Loading a legal configuration clears cfg_err.
- R7: When frame_start is seen while the mapper is idle, the next 12 clocks walk slots 1 to 12 in order. slot_num shows slot k one clock after the walk reaches it, and slot_valid is high only for owned slots. At most one FIFO is popped per clock, and only the FIFO of the owning channel.
- R8: A channel that owns several slots has its FIFO words consumed in ascending slot order: the first word goes to its lowest slot.
- R9: A sample of N bits (N = 12, 16, 18 or 20 for size codes 0 to 3) is taken from the low N bits of the FIFO word. It is placed in the top N bits of slot_data, and the low 20-N bits are zero.
- R10: If the owning FIFO is empty when its slot comes up, slot_valid is still asserted with slot_data zero, nothing is popped, and underrun[c] is set. The flag stays set until the next configuration load.
- R11: A frame_start pulse that arrives while a walk is in progress is ignored. The walk neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Loads and checks cfg_mask, cfg_size and cfg_compact |
| cfg_mask | input | NUM_CH*NUM_SLOTS | Per-channel slot ownership masks |
| cfg_size | input | NUM_CH*2 | Per-channel sample size codes |
| cfg_compact | input | NUM_CH | Per-channel compact-mode flags |
| frame_start | input | 1 | Starts a walk over the data slots |
| fifo_empty | input | NUM_CH | FIFO empty flags |
| fifo_rd_data | input | NUM_CH*SLOT_W | Head-of-FIFO words, valid while not empty |
| fifo_rd_en | output | NUM_CH | Pop strobes |
| slot_data | output | SLOT_W | Left-justified slot payload |
| slot_valid | output | 1 | slot_data belongs to an owned slot |
| slot_num | output | 4 | Slot number being presented (0 when idle) |
| cfg_err | output | 1 | Loaded configuration is illegal |
| underrun | output | NUM_CH | Sticky per-channel underrun flags |
| busy | output | 1 | Walk in progress |

## Verification
The assertions assume that the FIFOs behave as show-ahead queues: a word stays on fifo_rd_data while its empty flag is low, and it advances only on a pop. They also assume that cfg_load and frame_start are single-clock pulses driven from the same clock. The bench models each FIFO as a counter pair over a small ring, filled between frames and never beyond its depth. It changes configuration only between frames, except in the cases where the configuration is loaded on purpose to test the error path.

// File: rtl/txmap_pkg.sv
package txmap_pkg;

    typedef enum logic [1:0] {
        SZ_12 = 2'd0,
        SZ_16 = 2'd1,
        SZ_18 = 2'd2,
        SZ_20 = 2'd3
    } samp_size_e;

    localparam int SIZE_CODE_W = 2;

    function automatic int unsigned size_bits(samp_size_e s);
        case (s)
            SZ_12:   return 12;
            SZ_16:   return 16;
            SZ_18:   return 18;
            default: return 20;
        endcase
    endfunction

    function automatic logic compact_size_ok(samp_size_e s);
        return (s == SZ_12) || (s == SZ_16);
    endfunction

endpackage

// File: rtl/txmap_cfg_check.sv
module txmap_cfg_check
    import txmap_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_SLOTS  = 12,
    parameter int MAX_PER_CH = 8
) (
    input  logic [NUM_CH*NUM_SLOTS-1:0]   mask,
    input  logic [NUM_CH*SIZE_CODE_W-1:0] size,
    input  logic [NUM_CH-1:0]             compact,
    output logic                          bad
);
    localparam int CW = $clog2(NUM_SLOTS + 1);

    logic [NUM_CH-1:0] over_cap;
    logic [NUM_CH-1:0] size_bad;
    logic [NUM_CH-1:0] pair_bad;
    logic              overlap;
    logic              slot1_any;

    // per-channel checks repeat, one instance of logic per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_SLOTS-1:0] m;
        logic [CW-1:0]        cnt;
        assign m   = mask[c*NUM_SLOTS +: NUM_SLOTS];
        assign cnt = CW'($countones(m));
        assign over_cap[c] = (cnt > CW'(MAX_PER_CH));
        assign size_bad[c] = compact[c] &&
            !compact_size_ok(samp_size_e'(size[c*SIZE_CODE_W +: SIZE_CODE_W]));
        // slot 2 in this channel, slot 1 elsewhere, and a third slot here
        assign pair_bad[c] = m[1] && !m[0] && slot1_any &&
            (|(m & ~{{(NUM_SLOTS-2){1'b0}}, 2'b11}));
    end

    always_comb begin
        logic [NUM_SLOTS-1:0] seen;
        seen      = '0;
        overlap   = 1'b0;
        slot1_any = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            overlap   = overlap | (|(seen & mask[c*NUM_SLOTS +: NUM_SLOTS]));
            seen      = seen | mask[c*NUM_SLOTS +: NUM_SLOTS];
            slot1_any = slot1_any | mask[c*NUM_SLOTS];
        end
    end

    assign bad = overlap || (|over_cap) || (|size_bad) || (|pair_bad);

endmodule

// File: rtl/txmap_slot_owner.sv
module txmap_slot_owner #(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 12,
    parameter int CHW       = 2,
    parameter int SW        = 4
) (
    input  logic [NUM_CH*NUM_SLOTS-1:0] mask,
    input  logic [SW-1:0]               slot,
    output logic                        owned,
    output logic [CHW-1:0]              owner
);
    logic [NUM_CH-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        logic [NUM_SLOTS-1:0] m;
        assign m      = mask[c*NUM_SLOTS +: NUM_SLOTS];
        assign hit[c] = (slot != '0) && (slot <= SW'(NUM_SLOTS)) && m[slot - SW'(1)];
    end

    // lowest channel wins; exclusivity is enforced by the checker
    always_comb begin
        owned = 1'b0;
        owner = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (hit[c]) begin
                owned = 1'b1;
                owner = CHW'(c);
            end
        end
    end

endmodule

// File: rtl/txmap_align.sv
module txmap_align
    import txmap_pkg::*;
#(
    parameter int SLOT_W = 20
) (
    input  logic [SLOT_W-1:0] din,
    input  samp_size_e        sz,
    output logic [SLOT_W-1:0] dout
);
    logic [SLOT_W-1:0] keep;
    int unsigned       shift;

    always_comb begin
        shift = SLOT_W - size_bits(sz);
        keep  = {SLOT_W{1'b1}} >> shift;
        dout  = (din & keep) << shift;
    end

endmodule

// File: rtl/slot_tx_mapper.sv
module slot_tx_mapper
    import txmap_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_SLOTS  = 12,
    parameter int SLOT_W     = 20,
    parameter int MAX_PER_CH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [NUM_CH*NUM_SLOTS-1:0]   cfg_mask,
    input  logic [NUM_CH*SIZE_CODE_W-1:0] cfg_size,
    input  logic [NUM_CH-1:0]             cfg_compact,
    input  logic                          frame_start,
    input  logic [NUM_CH-1:0]             fifo_empty,
    input  logic [NUM_CH*SLOT_W-1:0]      fifo_rd_data,
    output logic [NUM_CH-1:0]             fifo_rd_en,
    output logic [SLOT_W-1:0]             slot_data,
    output logic                          slot_valid,
    output logic [3:0]                    slot_num,
    output logic                          cfg_err,
    output logic [NUM_CH-1:0]             underrun,
    output logic                          busy
);
    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SW  = $clog2(NUM_SLOTS + 1);

    typedef struct packed {
        logic [NUM_CH*NUM_SLOTS-1:0]   mask;
        logic [NUM_CH*SIZE_CODE_W-1:0] size;
        logic                          err;
        logic                          walk;
        logic [SW-1:0]                 slot;
        logic                          valid;
        logic [SW-1:0]                 num;
        logic [SLOT_W-1:0]             data;
        logic [NUM_CH-1:0]             urun;
    } state_t;

    state_t st_q, st_d;

    logic              cfg_bad;
    logic              owned;
    logic [CHW-1:0]    owner;
    samp_size_e        sel_size;
    logic [SLOT_W-1:0] sel_data;
    logic [SLOT_W-1:0] aligned;
    logic [NUM_CH-1:0] rd_en;

    txmap_cfg_check #(
        .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .MAX_PER_CH(MAX_PER_CH)
    ) i_check (
        .mask(cfg_mask), .size(cfg_size), .compact(cfg_compact), .bad(cfg_bad)
    );

    txmap_slot_owner #(
        .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .CHW(CHW), .SW(SW)
    ) i_owner (
        .mask(st_q.mask), .slot(st_q.slot), .owned(owned), .owner(owner)
    );

    assign sel_size = samp_size_e'(st_q.size[owner*SIZE_CODE_W +: SIZE_CODE_W]);
    assign sel_data = fifo_rd_data[owner*SLOT_W +: SLOT_W];

    txmap_align #(.SLOT_W(SLOT_W)) i_align (
        .din(sel_data), .sz(sel_size), .dout(aligned)
    );

    always_comb begin
        logic live;
        logic need;
        st_d  = st_q;
        rd_en = '0;
        live  = st_q.walk && !st_q.err && !cfg_load;
        need  = live && owned;

        st_d.valid = need;
        st_d.num   = live ? st_q.slot : '0;
        st_d.data  = '0;
        if (need) begin
            if (!fifo_empty[owner]) begin
                rd_en[owner] = 1'b1;
                st_d.data    = aligned;
            end else begin
                st_d.urun[owner] = 1'b1;
            end
        end

        if (cfg_load) begin
            st_d.mask = cfg_mask;
            st_d.size = cfg_size;
            st_d.err  = cfg_bad;
            st_d.walk = 1'b0;
            st_d.slot = '0;
            st_d.urun = '0;
        end else if (st_q.walk) begin
            if (st_q.slot == SW'(NUM_SLOTS)) begin
                st_d.walk = 1'b0;
                st_d.slot = '0;
            end else begin
                st_d.slot = st_q.slot + SW'(1);
            end
        end else if (frame_start && !st_q.err) begin
            st_d.walk = 1'b1;
            st_d.slot = SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_rd_en = rd_en;
    assign slot_data  = st_q.data;
    assign slot_valid = st_q.valid;
    assign slot_num   = 4'(st_q.num);
    assign cfg_err    = st_q.err;
    assign underrun   = st_q.urun;
    assign busy       = st_q.walk;

    // R7: a single FIFO at most is popped in any clock
    p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_rd_en));

    // R7: the walk advances by exactly one slot per clock
    p_walk_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.walk && !cfg_load && st_q.slot != SW'(NUM_SLOTS))
        |=> (st_q.walk && st_q.slot == $past(st_q.slot) + SW'(1)));

    // R7: a presented slot number always lies in the data-slot range
    p_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (slot_num >= 4'd1 && slot_num <= 4'(NUM_SLOTS)));

    // R6: an erroneous configuration never pops
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (fifo_rd_en == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R10: never pop an empty FIFO
        p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_rd_en[c] |-> !fifo_empty[c]);
        // R10: underrun holds until the next load
        p_urun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (underrun[c] && !cfg_load) |=> underrun[c]);
    end

endmodule

// File: tb/test_slot_tx_mapper.sv
module test_slot_tx_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NSL = 12;
    localparam int W   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [NCH*NSL-1:0] cfg_mask = '0;
    logic [NCH*2-1:0] cfg_size = '0;
    logic [NCH-1:0]   cfg_compact = '0;
    logic             frame_start = 1'b0;
    logic [NCH-1:0]   fifo_empty;
    logic [NCH*W-1:0] fifo_rd_data;
    logic [NCH-1:0]   fifo_rd_en;
    logic [W-1:0]     slot_data;
    logic             slot_valid;
    logic [3:0]       slot_num;
    logic             cfg_err;
    logic [NCH-1:0]   underrun;
    logic             busy;

    int total = 0;
    int bad   = 0;

    // FIFO model: show-ahead ring, 16 deep
    int         wp [NCH] = '{default: 0};
    int         rp [NCH] = '{default: 0};
    logic [W-1:0] mem [NCH][16];

    logic [NCH*NSL-1:0] cur_mask = '0;
    logic [NCH*2-1:0]   cur_size = '0;
    logic               cur_err  = 1'b0;
    logic [NCH-1:0]     exp_urun = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar c = 0; c < NCH; c++) begin : g_fifo
        assign fifo_empty[c] = (wp[c] == rp[c]);
        assign fifo_rd_data[c*W +: W] = mem[c][rp[c] % 16];
        always @(posedge clk) if (fifo_rd_en[c]) rp[c] <= rp[c] + 1;
    end

    slot_tx_mapper i_slot_tx_mapper (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mask(cfg_mask),
        .cfg_size(cfg_size), .cfg_compact(cfg_compact), .frame_start(frame_start),
        .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
        .slot_data(slot_data), .slot_valid(slot_valid), .slot_num(slot_num),
        .cfg_err(cfg_err), .underrun(underrun), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] val(int c, int p);
        return W'((c * 7919 + p * 4099 + 12345) ^ 20'h5A5A5);
    endfunction

    function automatic logic [W-1:0] just(logic [W-1:0] v, logic [1:0] code);
        int nb;
        nb = (code == 2'd0) ? 12 : (code == 2'd1) ? 16 : (code == 2'd2) ? 18 : 20;
        return (v & W'((1 << nb) - 1)) << (W - nb);
    endfunction

    task automatic push(int c, int n);
        for (int i = 0; i < n; i++) begin
            mem[c][wp[c] % 16] = val(c, wp[c]);
            wp[c] = wp[c] + 1;
        end
    endtask

    task automatic load(input logic [NCH*NSL-1:0] m, input logic [NCH*2-1:0] s,
                        input logic [NCH-1:0] cp, input logic exp_bad, input string req);
        @(negedge clk);
        cfg_mask = m; cfg_size = s; cfg_compact = cp; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cur_mask = m; cur_size = s; cur_err = exp_bad; exp_urun = '0;
        chk(req, 32'(cfg_err), 32'(exp_bad));
    endtask

    task automatic run_frame(input int fill [NCH], input logic mid_pulse);
        int er [NCH];
        int o;
        logic [W-1:0] e;
        for (int c = 0; c < NCH; c++) begin
            push(c, fill[c]);
            er[c] = rp[c];
        end
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 1; k <= NSL; k++) begin
            @(negedge clk);
            if (mid_pulse && k == 5) frame_start = 1'b1;
            if (mid_pulse && k == 6) frame_start = 1'b0;
            if (cur_err) begin
                chk("R6 valid", 32'(slot_valid), 0);
                chk("R6 busy", 32'(busy), 0);
                continue;
            end
            o = -1;
            for (int c = 0; c < NCH; c++) if (cur_mask[c*NSL + k - 1]) o = c;
            chk("R7 slot_num", 32'(slot_num), 32'(k));
            chk("R7 valid", 32'(slot_valid), 32'(o >= 0));
            e = '0;
            if (o >= 0) begin
                if (er[o] < wp[o]) begin
                    e = just(val(o, er[o]), cur_size[o*2 +: 2]);
                    er[o]++;
                end else begin
                    exp_urun[o] = 1'b1;
                end
            end
            chk("R8 R9 R10 data", 32'(slot_data), 32'(e));
        end
        @(negedge clk);
        chk("R11 valid after walk", 32'(slot_valid), 0);
        chk("R11 busy after walk", 32'(busy), 0);
        chk("R10 underrun", 32'(underrun), 32'(exp_urun));
        for (int c = 0; c < NCH; c++) chk("R8 pop count", 32'(rp[c]), 32'(er[c]));
    endtask

    function automatic logic [NCH*NSL-1:0] mk(logic [11:0] a, logic [11:0] b,
                                               logic [11:0] c, logic [11:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int full [NCH];
        int part [NCH];
        logic [NCH*NSL-1:0] cfg_a;
        logic [NCH*NSL-1:0] cfg_b;
        logic [NCH*NSL-1:0] m;
        logic [NCH*2-1:0] s;
        full = '{12, 12, 12, 12};
        cfg_a = mk(12'h003, 12'h01C, 12'h1E0, 12'hE00);
        cfg_b = mk(12'h555, 12'h002, 12'h0A8, 12'hA00);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(slot_valid), 0);
        chk("R1 num", 32'(slot_num), 0);
        chk("R1 data", 32'(slot_data), 0);
        chk("R1 err", 32'(cfg_err), 0);
        chk("R1 underrun", 32'(underrun), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rd_en", 32'(fifo_rd_en), 0);

        // R7 R8 R9: size sweep across channels
        for (int sw = 0; sw < 4; sw++) begin
            for (int c = 0; c < NCH; c++) s[c*2 +: 2] = 2'((sw + c) % 4);
            load(cfg_a, s, '0, 1'b0, "R2 legal a");
            full = '{2, 3, 4, 3};
            run_frame(full, 1'b0);
        end

        // R4 R5 R8: compact 12/16, slot 2 alone in its own channel
        load(cfg_b, 8'b01_00_01_00, 4'hF, 1'b0, "R5 legal b");
        full = '{6, 1, 3, 2};
        run_frame(full, 1'b0);

        // R10 underrun: ch1 short by two, ch3 empty; flags stay set
        load(cfg_a, 8'b11_10_01_00, '0, 1'b0, "R10 load");
        part = '{2, 1, 4, 0};
        run_frame(part, 1'b0);
        chk("R10 set", 32'(underrun), 32'(4'b1010));
        full = '{2, 3, 4, 3};
        run_frame(full, 1'b0);
        chk("R10 sticky", 32'(underrun), 32'(4'b1010));
        load(cfg_a, 8'b11_10_01_00, '0, 1'b0, "R10 reload");
        chk("R10 cleared", 32'(underrun), 0);

        // R11 frame_start during walk is ignored
        run_frame(full, 1'b1);

        // R3 cap sweep
        for (int c = 0; c < NCH; c++)
            for (int n = 1; n <= NSL; n++) begin
                m = '0;
                m[c*NSL +: NSL] = 12'((1 << n) - 1);
                load(m, '0, '0, n > 8, "R3 cap");
            end

        // R2 overlap sweep
        for (int a = 0; a < NCH; a++)
            for (int b = a + 1; b < NCH; b++)
                for (int sl = 0; sl < NSL; sl++) begin
                    m = '0;
                    m[a*NSL + sl] = 1'b1;
                    m[b*NSL + sl] = 1'b1;
                    load(m, '0, '0, 1'b1, "R2 overlap");
                    m[b*NSL + sl] = 1'b0;
                    m[b*NSL + (sl + 1) % NSL] = 1'b1;
                    load(m, '0, '0, 1'b0, "R2 disjoint");
                end

        // R4 compact size sweep
        for (int c = 0; c < NCH; c++)
            for (int code = 0; code < 4; code++)
                for (int cp = 0; cp < 2; cp++) begin
                    m = '0;
                    m[c*NSL + 2 + c] = 1'b1;
                    s = '0;
                    s[c*2 +: 2] = 2'(code);
                    load(m, s, NCH'(cp << c), (cp == 1) && (code >= 2), "R4 compact");
                end

        // R5 slot 1 / slot 2 placement
        for (int a = 0; a < NCH; a++)
            for (int b = 0; b < NCH; b++) begin
                if (a == b) continue;
                for (int sl = 2; sl < NSL; sl++) begin
                    m = '0;
                    m[a*NSL] = 1'b1;
                    m[b*NSL + 1] = 1'b1;
                    m[b*NSL + sl] = 1'b1;
                    load(m, '0, '0, 1'b1, "R5 shared");
                end
                m = '0;
                m[a*NSL] = 1'b1;
                m[a*NSL + 6] = 1'b1;
                m[b*NSL + 1] = 1'b1;
                load(m, '0, '0, 1'b0, "R5 alone");
            end
        load(mk(12'h013, 0, 0, 0), '0, '0, 1'b0, "R5 same channel");
        load(mk(0, 12'h012, 0, 0), '0, '0, 1'b0, "R5 no slot1");

        // R6 error blocks frames and pops; legal reload recovers
        load(mk(12'h003, 12'h002, 0, 0), '0, '0, 1'b1, "R6 bad load");
        push(0, 1);
        part = '{0, 0, 0, 0};
        run_frame(part, 1'b0);
        chk("R6 no pop", 32'(wp[0] - rp[0]), 1);
        load(cfg_a, '0, '0, 1'b0, "R6 recover");
        full = '{1, 3, 4, 3};
        run_frame(full, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule